// File: doc/BRIEF.md
# Walsh-Code Chip Despreader with Twin AND Accumulators

This block recovers one sender's data bit from a serial stream of merged spread chips. Before reception, the receiver loads the sender's ID, and the block expands that ID into the sender's Walsh code. Received chips then arrive one per strobe. Each chip is routed into one of two accumulators by the matching code chip. An accumulator holds a single bit that is ANDed with every chip routed into it. After the last chip of a symbol, the block compares the two accumulators and reports the decoded bit. No multiply or adder correlator is used.

A sender with data bit b transmits its code chips XOR b. For a clean stream, exactly one accumulator ends at 1, which gives the bit. If both accumulators agree, the block flags the symbol as ambiguous. Loading a new ID aborts any partial symbol and starts the next one from chip zero.

Top module: `cdma_despreader`

## Requirements
- R1: While rst_ni is low and after its release, bit_valid_o, bit_o and err_o are 0. The loaded ID is 0 and the chip position is 0.
- R2: For loaded ID i, code chip j (j = 0 is the first chip in time) equals the parity of the bitwise AND of i and j. The ID is captured on a cycle with id_load_i high.
- R3: Both accumulators start each symbol at 1. An accepted chip is ANDed into the zero-side accumulator when its code chip is 0, and into the one-side accumulator when it is 1. The other accumulator is left unchanged.
- R4: When the zero-side accumulator ends at 1 and the one-side accumulator ends at 0, bit_o is 1. When the zero-side ends at 0 and the one-side ends at 1, bit_o is 0.
- R5: When both accumulators end with the same value, err_o is 1 and bit_o is 0. Otherwise err_o is 0.
- R6: In the cycle after the eighth accepted chip, bit_valid_o is high for exactly one cycle. bit_o and err_o keep that result until the next symbol completes.
- R7: A cycle with chip_valid_i low accepts no chip. Gaps between chips do not change the result.
- R8: id_load_i restarts the symbol at chip 0 with both accumulators at 1. A chip presented in the same cycle as id_load_i is discarded. The new code applies from the next accepted chip.
- R9: With the merged stream 01111011 (first chip leftmost), the block gives bit 0 with no error for both ID 2 (code 00110011) and ID 5 (code 01011010). The stream 10100101 under ID 5 gives bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_load_i | input | 1 | Capture id_i and restart the symbol |
| id_i | input | 3 | Sender ID selecting the Walsh code |
| chip_valid_i | input | 1 | chip_i carries a chip this cycle |
| chip_i | input | 1 | Received merged chip |
| bit_valid_o | output | 1 | One-cycle strobe for a finished symbol |
| bit_o | output | 1 | Decoded data bit |
| err_o | output | 1 | Ambiguous symbol flag |

## Verification
The embedded assertions check on every cycle that:
- the valid strobe lasts one cycle and follows an accepted chip;
- an error result never carries a 1 bit;
- the outputs hold between strobes;
- an accumulator that has fallen to 0 stays there within a symbol;
- the accumulator not selected by the code chip is untouched;
- the chip counter clears on a load and steps on each accepted chip;
- the code does not change without a load.

Only the bench scenarios can show the following:
- the decoded bit and flag are correct against an independent model across all IDs;
- the worked merged-stream example decodes as stated;
- a reload in mid-symbol throws away the partial chips.

// File: rtl/cdma_despread_pkg.sv
package cdma_despread_pkg;
  // Walsh row `row`, chip `col`: parity of the shared set bits
  function automatic logic walsh_chip(input logic [31:0] row, input logic [31:0] col);
    return ^(row & col);
  endfunction
endpackage

// File: rtl/walsh_code_sel.sv
module walsh_code_sel #(
  parameter int CHIPS_P = 8,
  localparam int ID_W = $clog2(CHIPS_P)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ID_W-1:0]    id_i,
  output logic [CHIPS_P-1:0] code_o
);
  import cdma_despread_pkg::*;

  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (load_i) id_q <= id_i;
  end

  for (genvar j = 0; j < CHIPS_P; j++) begin : g_chip
    assign code_o[j] = walsh_chip(32'(id_q), 32'(j));
  end

  p_code_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(code_o));
endmodule

// File: rtl/chip_counter.sv
module chip_counter #(
  parameter int CHIPS_P = 8,
  localparam int CNT_W = $clog2(CHIPS_P)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CHIPS_P - 1);

  assign last_o = (idx_o == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (clear_i) idx_o <= '0;
    else if (step_i)  idx_o <= last_o ? '0 : idx_o + 1'b1;
  end

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> idx_o == '0);
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i) |=> $stable(idx_o));
  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && step_i && last_o) |=> idx_o == '0);
endmodule

// File: rtl/and_acc_pair.sv
module and_acc_pair (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic take_i,
  input  logic final_i,
  input  logic code_chip_i,
  input  logic chip_i,
  output logic acc0_nxt_o,
  output logic acc1_nxt_o
);
  logic acc0_q, acc1_q;

  // A chip only lowers the accumulator its code chip selects
  assign acc0_nxt_o = acc0_q & (code_chip_i | chip_i);
  assign acc1_nxt_o = acc1_q & (~code_chip_i | chip_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc0_q <= 1'b1;
      acc1_q <= 1'b1;
    end else if (restart_i || (take_i && final_i)) begin
      acc0_q <= 1'b1;
      acc1_q <= 1'b1;
    end else if (take_i) begin
      acc0_q <= acc0_nxt_o;
      acc1_q <= acc1_nxt_o;
    end
  end

  p_acc0_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !(take_i && final_i) && !acc0_q) |=> !acc0_q);
  p_acc1_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && !(take_i && final_i) && !acc1_q) |=> !acc1_q);
  p_steer_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !restart_i && !final_i && !code_chip_i) |=> $stable(acc1_q));
  p_steer_one_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !restart_i && !final_i && code_chip_i) |=> $stable(acc0_q));
  p_preset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (acc0_q && acc1_q));
endmodule

// File: rtl/cdma_despreader.sv
module cdma_despreader #(
  parameter int CHIPS_P = 8,
  localparam int ID_W  = $clog2(CHIPS_P),
  localparam int CNT_W = $clog2(CHIPS_P)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            id_load_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            chip_valid_i,
  input  logic            chip_i,
  output logic            bit_valid_o,
  output logic            bit_o,
  output logic            err_o
);
  logic [CHIPS_P-1:0] code;
  logic [CNT_W-1:0]   idx;
  logic               last, take, acc0_nxt, acc1_nxt;

  // A load wins over a chip in the same cycle
  assign take = chip_valid_i & ~id_load_i;

  walsh_code_sel #(.CHIPS_P(CHIPS_P)) u_code (
    .clk_i, .rst_ni, .load_i(id_load_i), .id_i, .code_o(code)
  );

  chip_counter #(.CHIPS_P(CHIPS_P)) u_cnt (
    .clk_i, .rst_ni, .clear_i(id_load_i), .step_i(take),
    .idx_o(idx), .last_o(last)
  );

  and_acc_pair u_acc (
    .clk_i, .rst_ni, .restart_i(id_load_i), .take_i(take), .final_i(last),
    .code_chip_i(code[idx]), .chip_i,
    .acc0_nxt_o(acc0_nxt), .acc1_nxt_o(acc1_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_valid_o <= 1'b0;
      bit_o       <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      bit_valid_o <= take & last;
      if (take && last) begin
        bit_o <= acc0_nxt & ~acc1_nxt;
        err_o <= ~(acc0_nxt ^ acc1_nxt);
      end
    end
  end

  p_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> ($stable(bit_o) && $stable(err_o)));
  p_err_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && err_o) |-> !bit_o);
  p_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |-> $past(chip_valid_i && !id_load_i));
endmodule

// File: tb/cdma_despreader_test.sv
module cdma_despreader_test;
  localparam int IDW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_load = 1'b0, chip_valid = 1'b0, chip = 1'b0;
  logic [IDW-1:0] id = '0;
  logic bit_valid, bit_out, err;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  cdma_despreader uut (
    .clk_i(clk), .rst_ni(rst_n), .id_load_i(id_load), .id_i(id),
    .chip_valid_i(chip_valid), .chip_i(chip),
    .bit_valid_o(bit_valid), .bit_o(bit_out), .err_o(err)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Code as an 8-bit literal, first chip leftmost
  function automatic logic [7:0] walsh(input int idv);
    logic [7:0] c;
    for (int j = 0; j < 8; j++) c[7-j] = ^(idv[2:0] & j[2:0]);
    return c;
  endfunction

  // {bit, err} from the twin-accumulator rule
  function automatic logic [1:0] model(input int idv, input logic [7:0] rx);
    logic a0 = 1'b1, a1 = 1'b1;
    logic [7:0] c = walsh(idv);
    for (int j = 0; j < 8; j++) begin
      if (c[7-j]) a1 = a1 & rx[7-j];
      else        a0 = a0 & rx[7-j];
    end
    return {a0 & ~a1, a0 == a1};
  endfunction

  task automatic load_id(input int v);
    @(negedge clk);
    id_load = 1'b1; id = v[IDW-1:0]; chip_valid = 1'b0;
    @(negedge clk);
    id_load = 1'b0;
  endtask

  task automatic send_sym(input logic [7:0] rx, input bit gaps,
                          input logic [1:0] exp_be, input string req);
    bit early = 0;
    logic [1:0] held;
    for (int j = 0; j < 8; j++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) begin
          @(negedge clk);
          chip_valid = 1'b0;
          if (bit_valid) early = 1;
        end
      end
      @(negedge clk);
      if (bit_valid) early = 1;
      chip_valid = 1'b1; chip = rx[7-j];
    end
    @(negedge clk);
    chip_valid = 1'b0;
    chk("R6 strobe after last chip", {7'b0, bit_valid}, 8'd1);
    chk("R6 no early strobe", {7'b0, early}, 8'd0);
    chk({req, " bit/err"}, {6'b0, bit_out, err}, {6'b0, exp_be});
    held = {bit_out, err};
    @(negedge clk);
    chk("R6 one-cycle strobe", {7'b0, bit_valid}, 8'd0);
    chk("R6 result held", {6'b0, bit_out, err}, {6'b0, held});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {5'b0, bit_valid, bit_out, err}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {5'b0, bit_valid, bit_out, err}, 8'd0);

    // R1: reset ID is 0, so the code is all zeros
    send_sym(8'hFF, 0, 2'b01, "R1 id0 all-ones stream");

    // R9 worked merged stream
    load_id(2);
    chk("R2 code id2", walsh(2), 8'b00110011);
    send_sym(8'b01111011, 0, 2'b00, "R9 id2 merged");
    load_id(5);
    chk("R2 code id5", walsh(5), 8'b01011010);
    send_sym(8'b01111011, 0, 2'b00, "R9 id5 merged");
    send_sym(8'b10100101, 1, 2'b10, "R9 id5 single bit1");
    load_id(2);
    send_sym(8'b00110011, 0, 2'b00, "R4 id2 single bit0");

    // R5 ambiguous symbols
    load_id(3);
    send_sym(8'hFF, 0, 2'b01, "R5 both ones");
    send_sym(8'h00, 1, 2'b01, "R5 both zeros");

    // R2/R4/R7 every nonzero ID, both bits, with gaps
    for (int i = 1; i < 8; i++) begin
      load_id(i);
      send_sym(~walsh(i), 1, 2'b10, "R4 bit1 sweep");
      send_sym(walsh(i), 1, 2'b00, "R4 bit0 sweep");
    end

    // R8 reload mid-symbol, chip in the load cycle is dropped
    load_id(3);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chip_valid = 1'b1; chip = 1'b0;
    end
    @(negedge clk);
    id_load = 1'b1; id = 3'd6; chip_valid = 1'b1; chip = 1'b0;
    @(negedge clk);
    id_load = 1'b0; chip_valid = 1'b0;
    chk("R8 no strobe on reload", {7'b0, bit_valid}, 8'd0);
    send_sym(~walsh(6), 0, 2'b10, "R8 after reload");

    // Random mix of single, merged and arbitrary streams
    begin
      int cur = 6;
      for (int n = 0; n < 150; n++) begin
        logic [7:0] rx;
        int kind = $urandom_range(0, 2);
        if ($urandom_range(0, 3) == 0) begin
          cur = $urandom_range(0, 7);
          load_id(cur);
        end
        if (kind == 0)
          rx = walsh(cur) ^ {8{1'($urandom_range(0, 1))}};
        else if (kind == 1)
          rx = (walsh(cur) ^ {8{1'($urandom_range(0, 1))}}) |
               (walsh($urandom_range(1, 7)) ^ {8{1'($urandom_range(0, 1))}});
        else
          rx = 8'($urandom);
        send_sym(rx, 1'($urandom_range(0, 1)), model(cur, rx), "R3 random");
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule